// File: doc/BRIEF.md
# Outbound Ordering Interlock Arbiter

This block merges posted writes from two producers, a DMA write queue and a processor write path, into one outbound request stream toward a downstream fabric. Writes leave in the order the block accepted them. Every outbound request carries the same stream identifier, so a component further down the path cannot tell DMA traffic from processor traffic. Because it has no basis for reordering, it has to keep the requests in order. A processor doorbell write issued after a DMA transfer therefore always follows that transfer's data.

The block also holds two kinds of processor-bound traffic: interrupt messages and read completions. Each is parked in its own single-entry slot. It is released only when every posted write the block accepted up to and including that slot's capture cycle has left on the outbound port. Writes that arrive later do not delay it. If interrupt messaging is disabled, software fetches the vector by a read, and the completion interlock alone pushes the posted data out ahead of that read.

Top module: `outbound_order_arbiter`

## Requirements
- R1: Every outbound request presents the shared stream identifier (parameter STREAM_ID, default 8'h5A) on out_id, whichever producer issued it.
- R2: Posted writes leave on the outbound port in the order they were accepted, with address and data unchanged.
- R3: At most one write is accepted per cycle. When both producers request and there is space, the grant alternates between them, and the DMA producer is served first after reset.
- R4: While DEPTH writes are pending, both write-ready outputs are low.
- R5: An interrupt message is not presented while any write accepted in or before its capture cycle is still unsent. It is presented in the cycle after the last such write is taken, or in the cycle after capture if none was pending.
- R6: A read completion follows the same drain rule as R5, using its own slot.
- R7: Writes accepted after a slot has captured its item do not delay that item's release.
- R8: Each slot holds one item. Its input ready is low while the slot is occupied, and the presented item stays stable until it is taken.
- R9: An outbound request stays valid and unchanged until out_ready takes it.
- R10: After reset no output is valid, and both slot input readies and the write-ready of a lone requester are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_valid | input | 1 | DMA write request |
| dma_ready | output | 1 | DMA write accepted |
| dma_addr | input | 16 | DMA write address |
| dma_data | input | 32 | DMA write data |
| cpu_valid | input | 1 | Processor write request |
| cpu_ready | output | 1 | Processor write accepted |
| cpu_addr | input | 16 | Processor write address |
| cpu_data | input | 32 | Processor write data |
| out_valid | output | 1 | Outbound request valid |
| out_ready | input | 1 | Fabric takes outbound request |
| out_addr | output | 16 | Outbound address |
| out_data | output | 32 | Outbound data |
| out_id | output | ID_W | Shared stream identifier |
| cpl_in_valid | input | 1 | Read completion offered |
| cpl_in_ready | output | 1 | Completion slot free |
| cpl_in_data | input | CPL_W | Completion payload |
| cpl_valid | output | 1 | Completion released to processor |
| cpl_ready | input | 1 | Processor takes completion |
| cpl_data | output | CPL_W | Released completion payload |
| irq_in_valid | input | 1 | Interrupt message offered |
| irq_in_ready | output | 1 | Interrupt slot free |
| irq_in_vec | input | VEC_W | Interrupt vector |
| irq_valid | output | 1 | Interrupt released to processor bus |
| irq_ready | input | 1 | Processor bus takes interrupt |
| irq_vec | output | VEC_W | Released vector |

## Verification
Write readies and slot input readies are combinational and are due in the same cycle the request is driven. A write accepted at a clock edge is at the outbound head in the cycle after that edge if the queue was empty. A captured slot item is released in the cycle after the edge that removed its last older write. The bench drives inputs on the falling edge, checks all outputs against a queue-based model shortly afterwards, and then advances the model to what the next rising edge produces, so each result is compared in the exact cycle it is due.

// File: rtl/ooi_pkg.sv
package ooi_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } pwr_t;

    typedef enum logic {
        TURN_DMA = 1'b0,
        TURN_CPU = 1'b1
    } turn_e;

    function automatic turn_e other_turn(turn_e t);
        return (t == TURN_DMA) ? TURN_CPU : TURN_DMA;
    endfunction

endpackage

// File: rtl/ooi_merge.sv
module ooi_merge
    import ooi_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic dma_valid,
    output logic dma_ready,
    input  pwr_t dma_wr,
    input  logic cpu_valid,
    output logic cpu_ready,
    input  pwr_t cpu_wr,
    input  logic space,
    output logic push,
    output pwr_t push_wr
);
    turn_e turn;
    logic  dma_take, cpu_take;

    always_comb begin
        dma_ready = space && (!cpu_valid || turn == TURN_DMA);
        cpu_ready = space && (!dma_valid || turn == TURN_CPU);
        dma_take  = dma_valid && dma_ready;
        cpu_take  = cpu_valid && cpu_ready;
        push      = dma_take || cpu_take;
        push_wr   = dma_take ? dma_wr : cpu_wr;
    end

    always_ff @(posedge clk) begin
        if (rst)
            turn <= TURN_DMA;
        else if (dma_take)
            turn <= other_turn(TURN_DMA);
        else if (cpu_take)
            turn <= other_turn(TURN_CPU);
    end

    assert_single_grant_R3: assert property (@(posedge clk) disable iff (rst)
        !(dma_take && cpu_take));

    assert_alternate_R3: assert property (@(posedge clk) disable iff (rst)
        dma_take |=> (!(dma_valid && cpu_valid && space) || cpu_take));

endmodule

// File: rtl/ooi_postq.sv
module ooi_postq
    import ooi_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  pwr_t             push_wr,
    output logic             out_valid,
    input  logic             out_ready,
    output pwr_t             head,
    output logic             drain,
    output logic             space,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] count_next
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    pwr_t             mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    always_comb begin
        out_valid  = (count != '0);
        head       = mem[rd_ptr];
        drain      = out_valid && out_ready;
        space      = (count != CNT_W'(DEPTH));
        count_next = count + CNT_W'(push) - CNT_W'(drain);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            count <= count_next;
            if (push) begin
                mem[wr_ptr] <= push_wr;
                wr_ptr      <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (drain)
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
        end
    end

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        (count == CNT_W'(DEPTH)) |-> !push);

    assert_head_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(head)));

endmodule

// File: rtl/ooi_gate.sv
module ooi_gate #(
    parameter int PAY_W = 8,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PAY_W-1:0] in_pay,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PAY_W-1:0] out_pay,
    input  logic [CNT_W-1:0] pend_now,
    input  logic [CNT_W-1:0] pend_next,
    input  logic             drain
);
    logic             full;
    logic [CNT_W-1:0] older;

    always_comb begin
        in_ready  = !full;
        out_valid = full && (older == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            full    <= 1'b0;
            older   <= '0;
            out_pay <= '0;
        end else if (!full) begin
            if (in_valid) begin
                full    <= 1'b1;
                out_pay <= in_pay;
                older   <= pend_next;   // everything queued by this edge is older
            end
        end else if (out_valid && out_ready) begin
            full <= 1'b0;
        end else if (drain && older != '0) begin
            older <= older - 1'b1;
        end
    end

    // On the completion instance these also guard R6.
    assert_older_bounded_R5: assert property (@(posedge clk) disable iff (rst)
        (full && older != '0) |-> (older <= pend_now));

    assert_release_next_R5: assert property (@(posedge clk) disable iff (rst)
        (full && older == CNT_W'(1) && drain) |=> out_valid);

    assert_slot_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pay)));

endmodule

// File: rtl/outbound_order_arbiter.sv
module outbound_order_arbiter
    import ooi_pkg::*;
#(
    parameter int              DEPTH     = 4,
    parameter int              ID_W      = 8,
    parameter logic [ID_W-1:0] STREAM_ID = 8'h5A,
    parameter int              CPL_W     = 32,
    parameter int              VEC_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dma_valid,
    output logic              dma_ready,
    input  logic [ADDR_W-1:0] dma_addr,
    input  logic [DATA_W-1:0] dma_data,
    input  logic              cpu_valid,
    output logic              cpu_ready,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data,
    output logic [ID_W-1:0]   out_id,
    input  logic              cpl_in_valid,
    output logic              cpl_in_ready,
    input  logic [CPL_W-1:0]  cpl_in_data,
    output logic              cpl_valid,
    input  logic              cpl_ready,
    output logic [CPL_W-1:0]  cpl_data,
    input  logic              irq_in_valid,
    output logic              irq_in_ready,
    input  logic [VEC_W-1:0]  irq_in_vec,
    output logic              irq_valid,
    input  logic              irq_ready,
    output logic [VEC_W-1:0]  irq_vec
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    pwr_t             dma_wr, cpu_wr, push_wr, head;
    logic             push, drain, space;
    logic [CNT_W-1:0] count, count_next;

    assign dma_wr   = '{addr: dma_addr, data: dma_data};
    assign cpu_wr   = '{addr: cpu_addr, data: cpu_data};
    assign out_addr = head.addr;
    assign out_data = head.data;
    assign out_id   = STREAM_ID;

    ooi_merge u_merge (
        .clk(clk), .rst(rst),
        .dma_valid(dma_valid), .dma_ready(dma_ready), .dma_wr(dma_wr),
        .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_wr(cpu_wr),
        .space(space), .push(push), .push_wr(push_wr)
    );

    ooi_postq #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_postq (
        .clk(clk), .rst(rst),
        .push(push), .push_wr(push_wr),
        .out_valid(out_valid), .out_ready(out_ready), .head(head),
        .drain(drain), .space(space), .count(count), .count_next(count_next)
    );

    ooi_gate #(.PAY_W(VEC_W), .CNT_W(CNT_W)) u_irq_gate (
        .clk(clk), .rst(rst),
        .in_valid(irq_in_valid), .in_ready(irq_in_ready), .in_pay(irq_in_vec),
        .out_valid(irq_valid), .out_ready(irq_ready), .out_pay(irq_vec),
        .pend_now(count), .pend_next(count_next), .drain(drain)
    );

    ooi_gate #(.PAY_W(CPL_W), .CNT_W(CNT_W)) u_cpl_gate (
        .clk(clk), .rst(rst),
        .in_valid(cpl_in_valid), .in_ready(cpl_in_ready), .in_pay(cpl_in_data),
        .out_valid(cpl_valid), .out_ready(cpl_ready), .out_pay(cpl_data),
        .pend_now(count), .pend_next(count_next), .drain(drain)
    );

    assert_empty_after_reset_R10: assert property (@(posedge clk)
        $fell(rst) |-> (!out_valid && !irq_valid && !cpl_valid));

endmodule

// File: tb/outbound_order_arbiter_test.sv
`timescale 1ns/1ps
module outbound_order_arbiter_test;
    localparam int DEPTH = 4;
    localparam logic [7:0] SID = 8'h5A;

    logic        clk = 1'b0, rst = 1'b1;
    logic        dma_valid = 0, cpu_valid = 0, out_ready = 0;
    logic [15:0] dma_addr = 0, cpu_addr = 0;
    logic [31:0] dma_data = 0, cpu_data = 0;
    logic        cpl_in_valid = 0, cpl_ready = 0, irq_in_valid = 0, irq_ready = 0;
    logic [31:0] cpl_in_data = 0;
    logic [7:0]  irq_in_vec = 0;
    logic        dma_ready, cpu_ready, out_valid, cpl_in_ready, cpl_valid;
    logic        irq_in_ready, irq_valid;
    logic [15:0] out_addr;
    logic [31:0] out_data, cpl_data;
    logic [7:0]  out_id, irq_vec;

    outbound_order_arbiter uut (.*);

    always #2 clk = ~clk;   // 250 MHz

    int checks = 0, errors = 0;
    bit done = 0;

    // reference model state
    logic [47:0] q[$];
    bit pref_dma;
    bit i_full, c_full;
    int i_wait, c_wait;
    logic [7:0]  i_vec;
    logic [31:0] c_pay;
    bit dma_took, cpu_took, irq_took, cpl_took;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        q.delete();
        pref_dma = 1; i_full = 0; c_full = 0; i_wait = 0; c_wait = 0;
        dma_took = 0; cpu_took = 0; irq_took = 0; cpl_took = 0;
    endtask

    // compare all outputs, then advance model to the next rising edge
    task automatic step_model();
        bit e_dr, e_cr, e_ov, e_iv, e_cv, dt, ct, pop;
        int nsz;
        e_dr = (q.size() < DEPTH) && (!cpu_valid || pref_dma);
        e_cr = (q.size() < DEPTH) && (!dma_valid || !pref_dma);
        e_ov = q.size() > 0;
        e_iv = i_full && i_wait == 0;
        e_cv = c_full && c_wait == 0;
        chk("R3 R4 dma_ready", dma_ready, e_dr);
        chk("R3 R4 cpu_ready", cpu_ready, e_cr);
        chk("R9 out_valid", out_valid, e_ov);
        if (e_ov) begin
            chk("R2 out_addr", out_addr, q[0][47:32]);
            chk("R2 out_data", out_data, q[0][31:0]);
            chk("R1 out_id", out_id, SID);
        end
        chk("R8 irq_in_ready", irq_in_ready, !i_full);
        chk("R8 cpl_in_ready", cpl_in_ready, !c_full);
        chk("R5 R7 irq_valid", irq_valid, e_iv);
        chk("R6 R7 cpl_valid", cpl_valid, e_cv);
        if (e_iv) chk("R8 irq_vec", irq_vec, i_vec);
        if (e_cv) chk("R8 cpl_data", cpl_data, c_pay);

        dt  = dma_valid && e_dr;
        ct  = cpu_valid && e_cr;
        pop = e_ov && out_ready;
        if (pop) void'(q.pop_front());
        if (dt) begin q.push_back({dma_addr, dma_data}); pref_dma = 0; end
        else if (ct) begin q.push_back({cpu_addr, cpu_data}); pref_dma = 1; end
        nsz = q.size();
        dma_took = dt; cpu_took = ct;
        irq_took = 0; cpl_took = 0;
        if (!i_full) begin
            if (irq_in_valid) begin i_full = 1; i_vec = irq_in_vec; i_wait = nsz; irq_took = 1; end
        end else if (e_iv && irq_ready) i_full = 0;
        else if (pop && i_wait > 0) i_wait--;
        if (!c_full) begin
            if (cpl_in_valid) begin c_full = 1; c_pay = cpl_in_data; c_wait = nsz; cpl_took = 1; end
        end else if (e_cv && cpl_ready) c_full = 0;
        else if (pop && c_wait > 0) c_wait--;
    endtask

    function automatic bit coin(int pct);
        return $urandom_range(99, 0) < pct;
    endfunction

    task automatic run_phase(int n, int p_wr, int p_ordy, int p_gate, int p_take);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (!dma_valid || dma_took) begin
                dma_valid = coin(p_wr); dma_addr = 16'($urandom); dma_data = $urandom;
            end
            if (!cpu_valid || cpu_took) begin
                cpu_valid = coin(p_wr); cpu_addr = 16'($urandom); cpu_data = $urandom;
            end
            if (!irq_in_valid || irq_took) begin
                irq_in_valid = coin(p_gate); irq_in_vec = 8'($urandom);
            end
            if (!cpl_in_valid || cpl_took) begin
                cpl_in_valid = coin(p_gate); cpl_in_data = $urandom;
            end
            out_ready = coin(p_ordy);
            irq_ready = coin(p_take);
            cpl_ready = coin(p_take);
            #1;
            step_model();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state, lone DMA requester sees ready
        dma_valid = 1;
        #1;
        chk("R10 out_valid", out_valid, 0);
        chk("R10 irq_valid", irq_valid, 0);
        chk("R10 cpl_valid", cpl_valid, 0);
        chk("R10 irq_in_ready", irq_in_ready, 1);
        chk("R10 cpl_in_ready", cpl_in_ready, 1);
        chk("R10 dma_ready", dma_ready, 1);
        dma_valid = 0;
        rst = 0;
        // outbound stalled: queue fills (R4), slots wait on older writes (R5, R6)
        run_phase(200, 80, 5, 30, 60);
        // writes keep arriving while slots drain (R7), steady mix
        run_phase(2000, 70, 50, 20, 50);
        // both producers hammering, alternation (R3) and ordering (R2)
        run_phase(2000, 100, 70, 10, 80);
        // slot back-pressure on the processor side (R8)
        run_phase(1500, 40, 90, 60, 15);
        // sparse traffic: gated items with nothing pending release next cycle
        run_phase(1500, 10, 90, 40, 90);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule